// File: doc/BRIEF.md
# Load/Store Access Size Unit

This unit sits between a register file of 32 registers, each 32 bits wide, and a data memory that is addressed by byte. Each accepted request moves data one way between one register and memory. A load fetches a memory word and writes the selected bytes into a register. A store writes bytes from a register, or from an immediate constant, into memory. The unit never copies data from one memory location to another.

The effective address is computed from one of three sources: an absolute constant, a register value, or a register value plus a constant offset. A two-bit size code selects a 1-byte, 2-byte or 4-byte transfer. Memory is little-endian, and byte lane `n` of the 32-bit memory word holds the byte at address bits `[1:0] == n`.

- On a store, the unit places the low bytes of the data onto the addressed lanes and drives a matching byte-enable mask.
- On a load, the unit takes the addressed lanes from the returned word and zero-extends them into the low part of the destination register.
- A request whose address is not aligned to its size makes no memory access and writes no register. Instead, a one-cycle error flag is raised.

The memory is assumed to have a registered read port with a latency of `RD_LAT` cycles, as block RAM does.

Top module: `xfer_unit`

## Requirements
- R1: While `rst` is high, and in the cycle after it falls, every output is zero.
- R2: The effective address EA is `req_const` when `req_amode` is 0, `req_base` when it is 1, and `req_base + req_const` (modulo 2^32) when it is 2 or 3. In the cycle after an accepted aligned request, `mem_addr` is EA with bits [1:0] cleared. `mem_addr` is zero in every cycle without an access.
- R3: Size code 0 selects 1 byte, size code 1 selects 2 bytes, and size codes 2 and 3 both select a full 4-byte word.
- R4: A store drives `mem_be` as follows: bit `EA[1:0]` for a byte, bits `EA[1:0]` and `EA[1:0]+1` for a halfword, and 4'hF for a word. A load drives `mem_be` to 0.
- R5: Store data byte k goes to lane `EA[1:0]+k` for each k below the transfer size. All other lanes of `mem_wdata` are zero.
- R6: The store data source is `req_sdata` when `req_dsel` is 0 and `req_imm` when `req_dsel` is 1.
- R7: An accepted aligned request raises `mem_en` in the next cycle, with `mem_we` high for a store and low for a load. A load then writes `rf_waddr = req_dest` with `rf_we` high exactly `RD_LAT+2` cycles after the request.
- R8: A byte or halfword load returns the lanes starting at `EA[1:0]` in the low bits of `rf_wdata`, with all upper bits zero.
- R9: A halfword with `EA[0]=1` is misaligned, and so is a word with `EA[1:0]!=0`. For a misaligned request, `misalign_err` is high for one cycle in the slot where the access would appear. In that cycle `mem_en`, `mem_we` and `mem_be` are zero, and no register write follows.
- R10: A cycle with `req_valid` low causes no memory access, no error flag and no register write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_store | input | 1 | 1 = store, 0 = load |
| req_size | input | 2 | Size code: 0 byte, 1 half, 2/3 word |
| req_amode | input | 2 | Address mode: 0 constant, 1 register, 2/3 register + offset |
| req_base | input | 32 | Base register value |
| req_const | input | 32 | Absolute address or offset |
| req_dsel | input | 1 | Store data source: 0 register, 1 immediate |
| req_sdata | input | 32 | Source register value |
| req_imm | input | 32 | Immediate store data |
| req_dest | input | 5 | Destination register index for loads |
| mem_en | output | 1 | Memory access strobe |
| mem_we | output | 1 | Memory write |
| mem_addr | output | 32 | Word-aligned byte address |
| mem_be | output | 4 | Byte-lane write enables |
| mem_wdata | output | 32 | Lane-steered write data |
| mem_rdata | input | 32 | Read word, `RD_LAT` cycles after the access |
| rf_we | output | 1 | Register write strobe |
| rf_waddr | output | 5 | Register index being written |
| rf_wdata | output | 32 | Zero-extended load result |
| misalign_err | output | 1 | One-cycle misaligned-access flag |

## Verification
The bench targets the following corner cases:

- **Lane placement.** Byte stores and byte loads cover all four lanes, and halfword accesses cover both halves. A design with reversed lane order would put data on the mirror lane.
- **Sign extension.** A loaded byte 0x80 or above must arrive zero-extended. A sign-extending design would fill the upper bits with ones.
- **Offset wraparound and size code 3.** A negative offset that wraps below the base checks the address arithmetic. Size code 3 must act as a word, not as a byte.
- **Misaligned requests.** A halfword at an odd address and words at every non-zero lane must raise only the error flag. A design that still wrote memory would corrupt a word, and the reference memory would expose this on a later load.
- **Store followed directly by a load.** A store to an address followed immediately by a load from the same address checks the byte-enable merge into memory.

// File: rtl/xfer_pkg.sv
package xfer_pkg;

  typedef enum logic [1:0] {
    XS_BYTE     = 2'd0,
    XS_HALF     = 2'd1,
    XS_WORD     = 2'd2,
    XS_WORD_ALT = 2'd3
  } xfer_size_e;

  typedef enum logic [1:0] {
    AM_CONST      = 2'd0,
    AM_REG        = 2'd1,
    AM_REGOFS     = 2'd2,
    AM_REGOFS_ALT = 2'd3
  } addr_mode_e;

  // Number of bytes moved for a size code, given the lane count of a word.
  function automatic int unsigned size_bytes(xfer_size_e sz, int unsigned lanes);
    case (sz)
      XS_BYTE: size_bytes = 1;
      XS_HALF: size_bytes = 2;
      default: size_bytes = lanes;
    endcase
  endfunction

endpackage

// File: rtl/xfer_addr_gen.sv
module xfer_addr_gen
  import xfer_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LANES  = 4
) (
  input  addr_mode_e        mode,
  input  xfer_size_e        size,
  input  logic [ADDR_W-1:0] base,
  input  logic [ADDR_W-1:0] cnst,
  output logic [ADDR_W-1:0] ea,
  output logic              misaligned
);
  localparam int LANE_W = $clog2(LANES);

  logic [LANE_W-1:0] align_mask;

  always_comb begin
    case (mode)
      AM_CONST: ea = cnst;
      AM_REG:   ea = base;
      default:  ea = base + cnst;
    endcase
  end

  always_comb begin
    case (size)
      XS_BYTE: align_mask = '0;
      XS_HALF: align_mask = LANE_W'(1);
      default: align_mask = '1;
    endcase
    misaligned = |(ea[LANE_W-1:0] & align_mask);
  end

endmodule

// File: rtl/xfer_store_lanes.sv
module xfer_store_lanes
  import xfer_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  xfer_size_e                   size,
  input  logic [$clog2(DATA_W/8)-1:0]  lane,
  input  logic [DATA_W-1:0]            src,
  output logic [DATA_W/8-1:0]          be,
  output logic [DATA_W-1:0]            wdata
);
  localparam int LANES  = DATA_W / 8;
  localparam int LANE_W = $clog2(LANES);

  logic [DATA_W-1:0] shifted;
  logic [LANE_W:0]   nbytes;

  always_comb begin
    shifted = src << {lane, 3'b000};
    nbytes  = (LANE_W+1)'(size_bytes(size, LANES));
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [LANE_W:0] rel;
    always_comb begin
      rel = (LANE_W+1)'(l) - {1'b0, lane};
      be[l] = (l >= int'(lane)) && (rel < nbytes);
      wdata[8*l +: 8] = be[l] ? shifted[8*l +: 8] : 8'h00;
    end
  end

  always_comb begin
    if (size == XS_BYTE) begin
      // R4
      byte_be_single_chk: assert ($countones(be) == 1);
    end
  end

endmodule

// File: rtl/xfer_load_extract.sv
module xfer_load_extract
  import xfer_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  xfer_size_e                   size,
  input  logic [$clog2(DATA_W/8)-1:0]  lane,
  input  logic [DATA_W-1:0]            rdata,
  output logic [DATA_W-1:0]            result
);
  localparam int LANES  = DATA_W / 8;
  localparam int LANE_W = $clog2(LANES);

  logic [DATA_W-1:0] shifted;
  int unsigned       nbytes;

  always_comb begin
    shifted = rdata >> {lane, 3'b000};
    nbytes  = size_bytes(size, LANES);
  end

  for (genvar l = 0; l < LANES; l++) begin : g_byte
    always_comb result[8*l +: 8] = (l < nbytes) ? shifted[8*l +: 8] : 8'h00;
  end

  always_comb begin
    if (size == XS_BYTE) begin
      // R8
      byte_zext_chk: assert (result[DATA_W-1:8] == '0);
    end
  end

endmodule

// File: rtl/xfer_unit.sv
module xfer_unit
  import xfer_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int REGS   = 32,
  parameter int RD_LAT = 1
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       req_valid,
  input  logic                       req_store,
  input  logic [1:0]                 req_size,
  input  logic [1:0]                 req_amode,
  input  logic [ADDR_W-1:0]          req_base,
  input  logic [ADDR_W-1:0]          req_const,
  input  logic                       req_dsel,
  input  logic [DATA_W-1:0]          req_sdata,
  input  logic [DATA_W-1:0]          req_imm,
  input  logic [$clog2(REGS)-1:0]    req_dest,
  output logic                       mem_en,
  output logic                       mem_we,
  output logic [ADDR_W-1:0]          mem_addr,
  output logic [DATA_W/8-1:0]        mem_be,
  output logic [DATA_W-1:0]          mem_wdata,
  input  logic [DATA_W-1:0]          mem_rdata,
  output logic                       rf_we,
  output logic [$clog2(REGS)-1:0]    rf_waddr,
  output logic [DATA_W-1:0]          rf_wdata,
  output logic                       misalign_err
);
  localparam int LANES  = DATA_W / 8;
  localparam int LANE_W = $clog2(LANES);
  localparam int REG_W  = $clog2(REGS);

  xfer_size_e        size_in;
  addr_mode_e        mode_in;
  logic [ADDR_W-1:0] ea;
  logic              misaligned;
  logic [DATA_W-1:0] st_src;
  logic [LANES-1:0]  st_be;
  logic [DATA_W-1:0] st_wdata;
  logic              go_ok;

  always_comb begin
    size_in = xfer_size_e'(req_size);
    mode_in = addr_mode_e'(req_amode);
    st_src  = req_dsel ? req_imm : req_sdata;
    go_ok   = req_valid && !misaligned;
  end

  xfer_addr_gen #(.ADDR_W(ADDR_W), .LANES(LANES)) u_agen (
    .mode       (mode_in),
    .size       (size_in),
    .base       (req_base),
    .cnst       (req_const),
    .ea         (ea),
    .misaligned (misaligned)
  );

  xfer_store_lanes #(.DATA_W(DATA_W)) u_st (
    .size  (size_in),
    .lane  (ea[LANE_W-1:0]),
    .src   (st_src),
    .be    (st_be),
    .wdata (st_wdata)
  );

  // Request stage: memory-side registers
  always_ff @(posedge clk) begin
    if (rst) begin
      mem_en       <= 1'b0;
      mem_we       <= 1'b0;
      mem_addr     <= '0;
      mem_be       <= '0;
      mem_wdata    <= '0;
      misalign_err <= 1'b0;
    end else begin
      mem_en       <= go_ok;
      mem_we       <= go_ok && req_store;
      mem_addr     <= go_ok ? {ea[ADDR_W-1:LANE_W], {LANE_W{1'b0}}} : '0;
      mem_be       <= (go_ok && req_store) ? st_be : '0;
      mem_wdata    <= (go_ok && req_store) ? st_wdata : '0;
      misalign_err <= req_valid && misaligned;
    end
  end

  // Load tracking delay line: stage 0 aligns with the access, stage RD_LAT with read data
  logic              ld_v    [RD_LAT+1];
  xfer_size_e        ld_size [RD_LAT+1];
  logic [LANE_W-1:0] ld_lane [RD_LAT+1];
  logic [REG_W-1:0]  ld_dest [RD_LAT+1];

  always_ff @(posedge clk) begin
    if (rst) begin
      ld_v[0]    <= 1'b0;
      ld_size[0] <= XS_BYTE;
      ld_lane[0] <= '0;
      ld_dest[0] <= '0;
    end else begin
      ld_v[0]    <= go_ok && !req_store;
      ld_size[0] <= size_in;
      ld_lane[0] <= ea[LANE_W-1:0];
      ld_dest[0] <= req_dest;
    end
  end

  for (genvar s = 1; s <= RD_LAT; s++) begin : g_ldpipe
    always_ff @(posedge clk) begin
      if (rst) begin
        ld_v[s]    <= 1'b0;
        ld_size[s] <= XS_BYTE;
        ld_lane[s] <= '0;
        ld_dest[s] <= '0;
      end else begin
        ld_v[s]    <= ld_v[s-1];
        ld_size[s] <= ld_size[s-1];
        ld_lane[s] <= ld_lane[s-1];
        ld_dest[s] <= ld_dest[s-1];
      end
    end
  end

  logic [DATA_W-1:0] ld_result;

  xfer_load_extract #(.DATA_W(DATA_W)) u_ld (
    .size   (ld_size[RD_LAT]),
    .lane   (ld_lane[RD_LAT]),
    .rdata  (mem_rdata),
    .result (ld_result)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rf_we    <= 1'b0;
      rf_waddr <= '0;
      rf_wdata <= '0;
    end else begin
      rf_we    <= ld_v[RD_LAT];
      rf_waddr <= ld_v[RD_LAT] ? ld_dest[RD_LAT] : '0;
      rf_wdata <= ld_v[RD_LAT] ? ld_result : '0;
    end
  end

  // R7
  we_needs_en_chk: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> mem_en);

  // R4
  store_be_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> (mem_be != '0));

  // R4
  load_be_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_en && !mem_we) |-> (mem_be == '0));

  // R9
  err_no_access_chk: assert property (@(posedge clk) disable iff (rst)
    misalign_err |-> (!mem_en && !mem_we && mem_be == '0));

  // R2
  addr_aligned_chk: assert property (@(posedge clk) disable iff (rst)
    mem_en |-> (mem_addr[LANE_W-1:0] == '0));

  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(req_valid) |-> (!mem_en && !misalign_err));

endmodule

// File: tb/sim_xfer_unit.sv
`timescale 1ns/1ps
module sim_xfer_unit;
  localparam int RD_LAT = 1;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst = 1'b1;
  logic        req_valid = 0, req_store = 0, req_dsel = 0;
  logic [1:0]  req_size = 0, req_amode = 0;
  logic [31:0] req_base = 0, req_const = 0, req_sdata = 0, req_imm = 0;
  logic [4:0]  req_dest = 0;
  logic        mem_en, mem_we, rf_we, misalign_err;
  logic [31:0] mem_addr, mem_wdata, rf_wdata;
  logic [31:0] mem_rdata = 0;
  logic [3:0]  mem_be;
  logic [4:0]  rf_waddr;

  xfer_unit #(.RD_LAT(RD_LAT)) u0 (.*);

  logic [31:0] ram     [256];
  logic [31:0] ref_mem [256];

  always @(posedge clk) begin
    if (mem_en) begin
      if (mem_we) begin
        for (int b = 0; b < 4; b++)
          if (mem_be[b]) ram[mem_addr[9:2]][8*b +: 8] <= mem_wdata[8*b +: 8];
      end else begin
        mem_rdata <= ram[mem_addr[9:2]];
      end
    end
  end

  int checks = 0, fails = 0, cyc = 0;
  logic        e_en = 0, e_we = 0, e_err = 0;
  logic [31:0] e_addr = 0, e_wd = 0;
  logic [3:0]  e_be = 0;
  string       e_tag = "R10";
  int          q_due[$];
  logic [4:0]  q_dst[$];
  logic [31:0] q_dat[$];
  string       q_tag[$];

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h (cycle %0d)", tag, what, act, exp, cyc);
    end
  endtask

  task automatic compare();
    chk(e_tag, "R7 mem_en", 32'(mem_en), 32'(e_en));
    chk(e_tag, "R7 mem_we", 32'(mem_we), 32'(e_we));
    chk(e_tag, "R2 mem_addr", mem_addr, e_addr);
    chk(e_tag, "R4 mem_be", 32'(mem_be), 32'(e_be));
    chk(e_tag, "R5 mem_wdata", mem_wdata, e_wd);
    chk(e_tag, "R9 misalign_err", 32'(misalign_err), 32'(e_err));
    if (q_due.size() > 0 && q_due[0] == cyc) begin
      chk(q_tag[0], "R7 rf_we", 32'(rf_we), 32'd1);
      chk(q_tag[0], "R7 rf_waddr", 32'(rf_waddr), 32'(q_dst[0]));
      chk(q_tag[0], "R8 rf_wdata", rf_wdata, q_dat[0]);
      void'(q_due.pop_front()); void'(q_dst.pop_front());
      void'(q_dat.pop_front()); void'(q_tag.pop_front());
    end else begin
      chk("R10", "rf_we idle", 32'(rf_we), 32'd0);
    end
  endtask

  // One cycle: check what the previous drive should have produced, then drive anew.
  task automatic step(string tag, logic v, logic st, logic [1:0] sz, logic [1:0] am,
                      logic [31:0] base, logic [31:0] cn, logic ds,
                      logic [31:0] sd, logic [31:0] im, logic [4:0] dst);
    logic [31:0] ea, data, word, res;
    int nb, lane;
    @(negedge clk);
    cyc++;
    compare();
    req_valid = v; req_store = st; req_size = sz; req_amode = am; req_base = base;
    req_const = cn; req_dsel = ds; req_sdata = sd; req_imm = im; req_dest = dst;
    ea   = (am == 0) ? cn : (am == 1) ? base : base + cn;
    nb   = (sz == 0) ? 1 : (sz == 1) ? 2 : 4;
    lane = int'(ea % 4);
    e_tag = tag; e_en = 0; e_we = 0; e_addr = 0; e_be = 0; e_wd = 0; e_err = 0;
    if (v) begin
      if ((ea % nb) != 0) e_err = 1;
      else begin
        e_en = 1; e_addr = ea & ~32'd3;
        if (st) begin
          e_we = 1;
          data = ds ? im : sd;
          for (int k = 0; k < nb; k++) begin
            e_be[lane+k] = 1'b1;
            e_wd[8*(lane+k) +: 8] = data[8*k +: 8];
            ref_mem[ea[9:2]][8*(lane+k) +: 8] = data[8*k +: 8];
          end
        end else begin
          word = ref_mem[ea[9:2]];
          res = 0;
          for (int k = 0; k < nb; k++) res[8*k +: 8] = word[8*(lane+k) +: 8];
          q_due.push_back(cyc + 2 + RD_LAT); q_dst.push_back(dst);
          q_dat.push_back(res); q_tag.push_back(tag);
        end
      end
    end
  endtask

  task automatic idle();
    step("R10", 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic st_op(string t, logic [1:0] sz, logic [1:0] am, logic [31:0] b,
                       logic [31:0] c, logic ds, logic [31:0] sd, logic [31:0] im);
    step(t, 1, 1, sz, am, b, c, ds, sd, im, 0);
  endtask

  task automatic ld_op(string t, logic [1:0] sz, logic [1:0] am, logic [31:0] b,
                       logic [31:0] c, logic [4:0] d);
    step(t, 1, 0, sz, am, b, c, 0, 32'hDEAD_BEEF, 0, d);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) begin
      ram[i] = (32'(i) * 32'h0103_0507) ^ 32'hC3A5_9617;
      ref_mem[i] = ram[i];
    end
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", "mem_en", 32'(mem_en), 0);
    chk("R1", "mem_we", 32'(mem_we), 0);
    chk("R1", "mem_be", 32'(mem_be), 0);
    chk("R1", "rf_we", 32'(rf_we), 0);
    chk("R1", "misalign_err", 32'(misalign_err), 0);
    rst = 1'b0;
    idle();
    // R2 address modes, R5/R6 data sources, R4 enables
    st_op("R2", 2, 0, 32'h0, 32'h40, 0, 32'h1122_3344, 0);
    st_op("R6", 2, 1, 32'h44, 32'h0, 1, 32'h0, 32'hCAFE_F00D);
    st_op("R2", 2, 2, 32'h50, 32'hFFFF_FFF8, 0, 32'hA1B2_C3D4, 0);
    for (int l = 0; l < 4; l++) st_op("R5", 0, 0, 0, 32'h60 + 32'(l), 1, 0, 32'h80 + 32'(l));
    st_op("R4", 1, 1, 32'h70, 0, 0, 32'h0000_9ABC, 0);
    st_op("R4", 1, 1, 32'h72, 0, 0, 32'hFFFF_E1F2, 0);
    st_op("R3", 3, 0, 0, 32'h80, 0, 32'h5566_7788, 0);
    // R7 loads, R8 lanes and zero-extension
    ld_op("R7", 2, 0, 0, 32'h40, 5'd1);
    ld_op("R7", 2, 2, 32'h50, 32'hFFFF_FFF8, 5'd31);
    for (int l = 0; l < 4; l++) ld_op("R8", 0, 2, 32'h60, 32'(l), 5'(l + 2));
    ld_op("R8", 1, 1, 32'h70, 0, 5'd7);
    ld_op("R8", 1, 1, 32'h72, 0, 5'd8);
    ld_op("R3", 3, 0, 0, 32'h81, 5'd9);
    ld_op("R3", 3, 0, 0, 32'h80, 5'd10);
    // R9 misaligned, then check memory untouched
    st_op("R9", 1, 0, 0, 32'h91, 0, 32'hFFFF_FFFF, 0);
    for (int l = 1; l < 4; l++) st_op("R9", 2, 0, 0, 32'h90 + 32'(l), 0, 32'hFFFF_FFFF, 0);
    ld_op("R9", 1, 0, 0, 32'h93, 5'd11);
    ld_op("R9", 2, 0, 0, 32'h90, 5'd12);
    // store then load same word back to back
    st_op("R5", 0, 0, 0, 32'hA2, 0, 32'h0000_00EE, 0);
    ld_op("R5", 2, 0, 0, 32'hA0, 5'd13);
    idle(); idle();
    // mixed patterns
    for (int n = 0; n < 400; n++) begin
      logic [31:0] b = $urandom_range(0, 1000);
      logic [31:0] c = $urandom_range(0, 15) - 8;
      logic [1:0]  sz = 2'($urandom_range(0, 3));
      logic [1:0]  am = 2'($urandom_range(0, 3));
      if (am == 0) c = $urandom_range(0, 1023);
      if ($urandom_range(0, 3) == 0) idle();
      else step("R3", 1, 1'($urandom_range(0, 1)), sz, am, b, c,
                1'($urandom_range(0, 1)), $urandom, $urandom, 5'($urandom_range(0, 31)));
    end
    repeat (RD_LAT + 4) idle();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(5.0 * 200000);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule